// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial EEPROM. It runs on a fast system clock and samples the bus clock and data lines through synchronizers. It finds start and stop conditions and decodes the addressing byte against its strapped pins. It then serves byte and page writes, current-address reads, random reads set up by a dummy write, and sequential reads. The data line is driven only through an active-high pull-low enable. The surrounding pad logic turns that enable into an open-drain output.

Write data for one page is collected in a page buffer. The storage array is written only after a stop condition arrives. A rewrite keeps the device busy for a fixed number of system clocks. During that time the device ignores the bus completely, so a master can poll with its own address until an acknowledge comes back. A write-protect input blocks rewrites to the upper half of the array, but the busy period still runs. An optional page-select mode takes the lowest slave-address bit as the top memory address bit, which doubles the array.

Top module: `twire_eeprom_slave`

## Requirements
- R1: After reset, `sda_pull_o` and `busy_o` are both 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Clocking a byte without a preceding start draws no acknowledge, and a stop always releases SDA.
- R3: The first byte after a start carries the device code 1010 in bits 7:4, the slave bits in bits 3:1 and R/W in bit 0, where 1 means read. The device acknowledges by pulling SDA low during the ninth SCL pulse, and only when the code and the compared slave bits equal `strap_i`.
- R4: With PAGE_SEL=1, bit 1 of the addressing byte is not compared against `strap_i[0]`. For a write it becomes bit 8 of the 9-bit memory address. For a read it is ignored and the internal pointer is used.
- R5: A write sends the addressing byte with R/W=0, then a word address byte, then data bytes, and each byte is acknowledged. The array is not changed and `busy_o` stays 0 until a stop arrives after at least one data byte. `busy_o` is then high for exactly BUSY_CYCLES clocks.
- R6: During a write, the low PAGE_W address bits advance after each data byte and wrap within the page. The upper bits never change, and a later byte landing on an earlier offset replaces it.
- R7: While `busy_o` is 1, the device never pulls SDA and does not acknowledge even its own address. A poll after the busy period ends is acknowledged.
- R8: With `wp_i`=1 at the stop, bytes whose address MSB is 1 are not written. Bytes in the lower half are written, and the busy period still runs in full.
- R9: Read data leaves MSB first and changes only while SCL is low. The pointer advances by one after each byte sent, so a read with no word address starts at the pointer left by the previous access.
- R10: A master acknowledge after a read byte continues with the next address. The pointer wraps from the last array address to 0.
- R11: A stop right after the word address loads the pointer, starts no rewrite and leaves `busy_o` at 0.
- R12: A master no-acknowledge followed by a stop returns the device to idle, ready for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Strapped slave-address bits |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | High while an array rewrite is in progress |

## Verification
The bench builds the block with PAGE_SEL=1, PAGE_W=4 and BUSY_CYCLES=2000. The 512-byte array puts the page-select bit, the protected upper half and the wrap from 0x1FF to 0x000 within reach of a short sequence. Sixteen-byte pages make a page rollover quick to provoke. The short busy period lets acknowledge polling first see refusals and then see the device return, and the bench checks the exact busy length each time.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RMACK
  } twe_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Addressing byte: [7:4] code, [3:1] slave bits, [0] read/write.
  function automatic logic dev_match(logic [7:0] b, logic [2:0] strap, bit page_sel);
    logic lsb_ok;
    lsb_ok = page_sel ? 1'b1 : (b[1] == strap[0]);
    return (b[7:4] == DEV_CODE) && (b[3:2] == strap[2:1]) && lsb_ok;
  endfunction

  // Advance the low pw bits only, wrapping inside the page.
  function automatic logic [15:0] page_next(logic [15:0] a, int unsigned pw);
    logic [15:0] mask;
    mask = (16'd1 << pw) - 16'd1;
    return (a & ~mask) | ((a + 16'd1) & mask);
  endfunction

endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twe_mem.sv
module twe_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end

endmodule

// File: rtl/twe_commit.sv
module twe_commit #(
  parameter int AW          = 8,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_we,
  input  logic [PAGE_W-1:0] cap_off,
  input  logic [7:0]        cap_data,
  input  logic              go,
  input  logic [AW-1:0]     base,
  input  logic              wp,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              busy
);
  localparam int PB = 1 << PAGE_W;
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]        pbuf [PB];
  logic [PB-1:0]     vld;
  logic [CW-1:0]     bcnt;
  logic              act;
  logic [PAGE_W-1:0] idx;
  logic [AW-1:0]     base_q;
  logic              prot_q;

  always_ff @(posedge clk) begin
    if (cap_we) pbuf[cap_off] <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      bcnt   <= '0;
      act    <= 1'b0;
      idx    <= '0;
      base_q <= '0;
      prot_q <= 1'b0;
    end else begin
      if (go) begin
        bcnt   <= CW'(BUSY_CYCLES);
        act    <= 1'b1;
        idx    <= '0;
        base_q <= base;
        prot_q <= wp;
      end else begin
        if (bcnt != '0) bcnt <= bcnt - CW'(1);
        if (act) begin
          idx <= idx + PAGE_W'(1);
          if (idx == PAGE_W'(PB - 1)) act <= 1'b0;
        end
      end
      if (clear || (act && idx == PAGE_W'(PB - 1))) vld <= '0;
      else if (cap_we) vld[cap_off] <= 1'b1;
    end
  end

  assign mem_we    = act & vld[idx] & ~(prot_q & base_q[AW-1]);
  assign mem_waddr = {base_q[AW-1:PAGE_W], idx};
  assign mem_wdata = pbuf[idx];
  assign busy      = (bcnt != '0);

endmodule

// File: rtl/twe_engine.sv
module twe_engine
  import twe_pkg::*;
#(
  parameter int PAGE_SEL = 0,
  parameter int PAGE_W   = 3,
  parameter int AW       = 8 + PAGE_SEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata,
  output logic [AW-1:0]     ptr,
  output logic              sda_pull,
  output logic              buf_clear,
  output logic              cap_we,
  output logic [PAGE_W-1:0] cap_off,
  output logic [7:0]        cap_data,
  output logic              commit_go
);
  twe_state_e  st;
  logic [3:0]  cnt;
  logic [7:0]  shreg;
  logic        rw_q;
  logic        page_q;
  logic        ack_q;
  logic [7:0]  out_sh;
  logic        mack_ok;
  logic        have_data;
  logic        match;
  logic        quiet;
  logic [AW-1:0] load_addr;

  assign match = dev_match(shreg, strap, PAGE_SEL != 0);
  assign quiet = busy_i | stop_det | start_det;

  generate
    if (PAGE_SEL != 0) begin : g_page
      assign load_addr = {page_q, shreg};
    end else begin : g_flat
      assign load_addr = shreg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rw_q      <= 1'b0;
      page_q    <= 1'b0;
      ptr       <= '0;
      ack_q     <= 1'b0;
      out_sh    <= '1;
      mack_ok   <= 1'b0;
      have_data <= 1'b0;
    end else if (busy_i || stop_det) begin
      st        <= ST_IDLE;
      ack_q     <= 1'b0;
      have_data <= 1'b0;
    end else if (start_det) begin
      st        <= ST_DEV;
      cnt       <= '0;
      ack_q     <= 1'b0;
      have_data <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
          if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_DEV) begin
              if (match) begin
                st     <= ST_DEV_ACK;
                ack_q  <= 1'b1;
                rw_q   <= shreg[0];
                page_q <= shreg[1];
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADR) begin
              st        <= ST_WADR_ACK;
              ack_q     <= 1'b1;
              ptr       <= load_addr;
              have_data <= 1'b0;
            end else begin
              st        <= ST_WDAT_ACK;
              ack_q     <= 1'b1;
              ptr       <= AW'(page_next(16'(ptr), PAGE_W));
              have_data <= 1'b1;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            if (rw_q) begin
              st     <= ST_RDAT;
              out_sh <= mem_rdata;
            end else begin
              st <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            st    <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st  <= ST_RMACK;
              cnt <= '0;
              ptr <= ptr + AW'(1);
            end else begin
              out_sh <= {out_sh[6:0], 1'b1};
              cnt    <= cnt + 4'd1;
            end
          end
        end
        ST_RMACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              st     <= ST_RDAT;
              out_sh <= mem_rdata;
              cnt    <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull  = ack_q | ((st == ST_RDAT) & ~out_sh[7]);
  assign cap_we    = ~quiet & (st == ST_WDAT) & scl_fall & (cnt == 4'd8);
  assign cap_off   = ptr[PAGE_W-1:0];
  assign cap_data  = shreg;
  assign buf_clear = ~quiet & (st == ST_DEV_ACK) & scl_fall & ~rw_q;
  assign commit_go = stop_det & ~busy_i & have_data &
                     ((st == ST_WDAT) | (st == ST_WDAT_ACK));

endmodule

// File: rtl/twire_eeprom_slave.sv
module twire_eeprom_slave #(
  parameter int PAGE_SEL    = 0,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  localparam int MEM_AW = 8 + PAGE_SEL;

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [MEM_AW-1:0] ptr;
  logic              buf_clear, cap_we, commit_go;
  logic [PAGE_W-1:0] cap_off;
  logic [7:0]        cap_data;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              busy;

  twe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twe_engine #(.PAGE_SEL(PAGE_SEL), .PAGE_W(PAGE_W), .AW(MEM_AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .busy_i(busy), .mem_rdata(mem_rdata), .ptr(ptr),
    .sda_pull(sda_pull_o), .buf_clear(buf_clear), .cap_we(cap_we),
    .cap_off(cap_off), .cap_data(cap_data), .commit_go(commit_go)
  );

  twe_commit #(.AW(MEM_AW), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .cap_we(cap_we),
    .cap_off(cap_off), .cap_data(cap_data), .go(commit_go), .base(ptr),
    .wp(wp_i), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  twe_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(mem_rdata)
  );

  assign busy_o = busy;

endmodule

// File: rtl/twe_checker.sv
module twe_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic pull,
  input logic scl_s,
  input logic stop_det,
  input logic mem_we
);
  a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pull);

  a_r5_array_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r5_busy_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pull != $past(pull)) |-> !$past(scl_s));

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !pull);

endmodule

bind twire_eeprom_slave twe_checker u_twe_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .pull(sda_pull_o),
  .scl_s(scl_s), .stop_det(stop_det), .mem_we(mem_we)
);

// File: tb/twire_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twire_eeprom_slave_bench;
  localparam int PAGE_SEL = 1;
  localparam int PAGE_W   = 4;
  localparam int BUSY     = 2000;
  localparam int H        = 16;
  localparam logic [2:0] STRAP = 3'b111;
  localparam int ASIZE    = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull, busy;
  wire  sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  twire_eeprom_slave #(.PAGE_SEL(PAGE_SEL), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY))
    u_twire_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .strap_i(STRAP), .wp_i(wp), .sda_pull_o(sda_pull), .busy_o(busy)
    );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [int];
  int ref_ptr = 0;
  int busy_run = 0, last_len = 0, busy_rises = 0, quiet_viol = 0;
  logic busy_prev = 1'b0;

  // Per-clock reference observation of the busy window.
  always @(negedge clk) begin
    if (busy && sda_pull) quiet_viol++;
    if (busy) busy_run++;
    else if (busy_run != 0) begin last_len = busy_run; busy_run = 0; end
    if (busy && !busy_prev) busy_rises++;
    busy_prev = busy;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp();
    scl = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
      repeat (2) @(negedge clk);
    end
    sda_m = 1'b1; hp(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (H/2) @(negedge clk);
    scl = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; hp(); scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (H/2) @(negedge clk);
      scl = 1'b0; repeat (2) @(negedge clk);
    end
    sda_m = !mack; hp(); scl = 1'b1; hp(); scl = 1'b0;
    repeat (2) @(negedge clk); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(input bit pg, input bit rd);
    return {4'b1010, STRAP[2:1], pg, rd};
  endfunction

  task automatic wait_ready();
    int nacks = 0;
    bit ack = 0;
    for (int k = 0; k < 40 && !ack; k++) begin
      bus_start(); send_byte(devb(1'b0, 1'b0), ack); bus_stop();
      if (!ack) nacks++;
    end
    chk("R7 polls refused while busy", (nacks > 0), 1);
    chk("R7 poll acknowledged after busy", ack, 1);
    chk("R5 busy length", last_len, BUSY);
    chk("R7 no pull during busy", quiet_viol, 0);
  endtask

  task automatic wr(input int addr, input logic [7:0] dq[$]);
    bit ack;
    int a = addr;
    bus_start();
    send_byte(devb(addr[8], 1'b0), ack); chk("R3 write address ack", ack, 1);
    send_byte(addr[7:0], ack); chk("R5 word address ack", ack, 1);
    foreach (dq[i]) begin
      send_byte(dq[i], ack); chk("R5 data ack", ack, 1);
      if (!(wp && a[8])) ref_mem[a] = dq[i];
      a = (a & ~((1 << PAGE_W) - 1)) | ((a + 1) & ((1 << PAGE_W) - 1));
    end
    chk("R5 no busy before stop", busy, 0);
    bus_stop();
    ref_ptr = a;
    wait_ready();
  endtask

  task automatic rd(input int addr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    if (addr >= 0) begin
      bus_start();
      send_byte(devb(addr[8], 1'b0), ack); chk("R11 dummy address ack", ack, 1);
      send_byte(addr[7:0], ack); chk("R11 dummy word ack", ack, 1);
      ref_ptr = addr;
    end
    bus_start();
    send_byte(devb(~ref_ptr[8], 1'b1), ack); chk("R4 read ack, page bit ignored", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(req, b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % ASIZE;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ack;
    int rises;
    repeat (5) @(negedge clk);
    chk("R1 reset pull", sda_pull, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2: byte clocked with no start condition
    scl = 1'b0; hp();
    send_byte(devb(1'b0, 1'b0), ack); chk("R2 no ack without start", ack, 0);
    bus_stop();

    // R3: wrong code, wrong slave bits
    bus_start(); send_byte(8'b1011_1100, ack); bus_stop();
    chk("R3 wrong device code", ack, 0);
    bus_start(); send_byte({4'b1010, ~STRAP[2:1], 2'b00}, ack); bus_stop();
    chk("R3 wrong slave bits", ack, 0);
    chk("R3 no busy after mismatch", busy_rises, 0);

    wr(9'h010, '{8'h3C});

    // R11: dummy write then stop, then current-address read
    rises = busy_rises;
    bus_start(); send_byte(devb(1'b0, 1'b0), ack); send_byte(8'h10, ack); bus_stop();
    repeat (40) @(negedge clk);
    chk("R11 dummy starts no rewrite", busy_rises, rises);
    ref_ptr = 9'h010;
    rd(-1, 1, "R11 pointer loaded by dummy write");

    // R6: page rollover
    wr(9'h07C, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    rd(9'h070, 2, "R6 wrapped bytes at page start");
    rd(9'h07C, 4, "R6 bytes before wrap");

    // R4: page-select bit
    wr(9'h110, '{8'hA5});
    rd(9'h110, 1, "R4 upper page data");
    rd(9'h010, 1, "R4 lower page untouched");

    // R8: write protect
    wr(9'h120, '{8'h77});
    wp = 1'b1;
    wr(9'h120, '{8'h5A});
    wr(9'h020, '{8'h99});
    wp = 1'b0;
    rd(9'h120, 1, "R8 protected byte kept");
    rd(9'h020, 1, "R8 lower half written");

    // R10: sequential read wraps, R9 current read, R12 ready after NACK
    wr(9'h1FE, '{8'hE1, 8'hE2});
    wr(9'h000, '{8'h0A, 8'h0B});
    rd(9'h1FE, 3, "R10 sequential read across wrap");
    rd(-1, 1, "R9 current-address read");
    chk("R12 idle after NACK and stop", sda_pull, 0);
    bus_start(); send_byte(devb(1'b0, 1'b0), ack); bus_stop();
    chk("R12 next start accepted", ack, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule